// File: doc/BRIEF.md
# Seconds Counter with Delayed-Commit Alarm

This block is a register-mapped real-time clock that holds a 32-bit count of seconds. A one-cycle pulse on `sec_tick` marks each second, and each pulse advances the count by one. The block also holds an alarm compare value and a one-bit interrupt enable. When the count steps past the alarm value, an interrupt flag is set. The `irq` output drives the interrupt line and is the flag gated by the enable.

A write never changes the running state at once. Writes that load the time, set the alarm, acknowledge the interrupt or change the enable each go into their own holding slot. The slot commits its value on the `DELAY_TICKS`-th second pulse after the write that armed it. This models a slow write path into an always-on domain. Software polls a status word to learn which commits are still outstanding. The load-time register reads back whatever was last written to it, not the running count.

The bus is a plain single-cycle register interface addressed by word index. A write happens in any cycle where `bus_sel` and `bus_wr` are both high. Read data is a combinational function of `bus_word` while `bus_sel` is high and `bus_wr` is low.

Top module: `sec_rtc`

## Requirements
- R1: Word 0 reads the running count. On every clock edge with `sec_tick` high the count goes up by exactly one, wrapping modulo 2^32, except on an edge where a time load commits. Writes to word 0 have no effect.
- R2: A write to word 2 commits its value into the count on the `DELAY_TICKS`-th tick edge after the write, replacing that edge's increment. Word 2 always reads the last value written to it.
- R3: A write to word 1 commits as the alarm value on the `DELAY_TICKS`-th tick edge after the write. Word 1 reads the committed alarm value.
- R4: The interrupt flag is set on a tick edge where the count equals the committed alarm value and no time load commits on that edge. The `irq` output is the flag AND the committed enable.
- R5: Bit 0 of word 4 reads the value of `irq`. Writing word 4 with bit 0 = 1 clears the flag on the `DELAY_TICKS`-th tick edge after that write. If a set event happens on the same edge, the set wins. Writing word 4 with bit 0 = 0 does nothing and arms no status bit.
- R6: Bit 0 of a write to word 3 commits as the interrupt enable on the `DELAY_TICKS`-th tick edge after the write. Word 3 reads the committed enable.
- R7: Word 5 is a status word: bit 0 time load, bit 1 alarm load, bit 2 acknowledge, bit 3 enable change, with the other bits zero. A bit reads 1 from the edge after its write until the tick edge on which that operation commits.
- R8: A second write of the same kind while that kind is pending replaces the held value. The countdown is not restarted, so the newest value commits at the time set by the first write.
- R9: While `rst_n` is low, the count, alarm, enable, flag, last-written time and all status bits are cleared to zero.
- R10: Word indices 6 and above read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and state clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | ADDR_W (4) | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt line, flag gated by enable |

## Verification
If a holding slot's countdown is wrong, the count, alarm or enable reads change one tick too early or too late. The matching status bit also clears on the wrong edge, so the bench sees the fault at the first read after the affected tick. A flag that sets on the wrong edge, or fails to clear, appears on `irq` in the same cycle as the error. A rewrite that restarts the countdown makes the status bit stay high past the expected commit edge. A count that skips or holds is visible at word 0 after the next tick.

// File: rtl/rtc_pkg.sv
// Package: shared constants for the seconds counter.
// Holds the register word map and the operation indices used by the
// holding slots and the status word. The status bit order is fixed.
package rtc_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NUM_OPS  = 4;

    // Register word indices
    localparam int unsigned W_NOW    = 0;
    localparam int unsigned W_ALARM  = 1;
    localparam int unsigned W_LOAD   = 2;
    localparam int unsigned W_ENABLE = 3;
    localparam int unsigned W_IRQ    = 4;
    localparam int unsigned W_STATUS = 5;

    // Status bit positions, one per delayed operation
    typedef enum logic [1:0] {
        OP_TIME  = 2'd0,
        OP_ALARM = 2'd1,
        OP_ACK   = 2'd2,
        OP_EN    = 2'd3
    } rtc_op_e;
endpackage

// File: rtl/rtc_pend_slot.sv
// Module: rtc_pend_slot
// Holding slot for one kind of delayed write. A write arms the slot and
// loads a countdown with DELAY. Every tick while armed decrements it, and
// the tick that finds the countdown at one raises apply_stb and disarms.
// A write while armed replaces the held value and keeps the countdown.
// Assumes DELAY >= 1 and at most one write strobe per cycle.
module rtc_pend_slot #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DELAY = 2,
    localparam int unsigned CD_W = (DELAY < 2) ? 1 : $clog2(DELAY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wr_val,
    output logic             pending,
    output logic             apply_stb,
    output logic [WIDTH-1:0] held
);
    logic [CD_W-1:0]  cd_q;
    logic             arm_q;
    logic [WIDTH-1:0] val_q;

    // Commit strobe: armed, tick present, last step of the countdown
    assign apply_stb = arm_q && tick && (cd_q == CD_W'(1));
    assign pending   = arm_q;
    assign held      = val_q;

    // Countdown, arm flag and held value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_q  <= '0;
            arm_q <= 1'b0;
            val_q <= '0;
        end else begin
            if (apply_stb) begin
                arm_q <= 1'b0;
            end else if (arm_q && tick) begin
                cd_q <= cd_q - CD_W'(1);
            end
            if (wr_stb) begin
                val_q <= wr_val;
                if (!arm_q || apply_stb) begin
                    arm_q <= 1'b1;
                    cd_q  <= CD_W'(DELAY);
                end
            end
        end
    end
endmodule

// File: rtl/rtc_core.sv
// Module: rtc_core
// Committed state of the clock: seconds count, alarm value, interrupt
// enable and the raw interrupt flag. It only changes on commit strobes
// from the holding slots and on second ticks.
// Assumes commit strobes arrive only in cycles with tick high.
module rtc_core #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              time_apply,
    input  logic [DATA_W-1:0] time_val,
    input  logic              alarm_apply,
    input  logic [DATA_W-1:0] alarm_val,
    input  logic              ack_apply,
    input  logic              ack_val,
    input  logic              en_apply,
    input  logic              en_val,
    output logic [DATA_W-1:0] now,
    output logic [DATA_W-1:0] alarm,
    output logic              enable,
    output logic              flag,
    output logic              irq
);
    logic [DATA_W-1:0] now_q;
    logic [DATA_W-1:0] alarm_q;
    logic              en_q;
    logic              flag_q;
    logic              hit;

    // Alarm event: a normal increment starting from the alarm value
    assign hit = tick && !time_apply && (now_q == alarm_q);

    // Seconds counter with delayed load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= '0;
        end else if (time_apply) begin
            now_q <= time_val;
        end else if (tick) begin
            now_q <= now_q + DATA_W'(1);
        end
    end

    // Committed alarm value and interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            en_q    <= 1'b0;
        end else begin
            if (alarm_apply) alarm_q <= alarm_val;
            if (en_apply)    en_q    <= en_val;
        end
    end

    // Raw interrupt flag: set on alarm event, cleared by committed ack
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (ack_apply && ack_val) begin
            flag_q <= 1'b0;
        end
    end

    assign now    = now_q;
    assign alarm  = alarm_q;
    assign enable = en_q;
    assign flag   = flag_q;
    assign irq    = flag_q & en_q;
endmodule

// File: rtl/rtc_regif.sv
// Module: rtc_regif
// Register interface: decodes write strobes per delayed operation and
// builds the combinational read data from committed state, the last
// written time and the status bits. Unmapped words read zero.
// Assumes a single-cycle bus with no wait states.
module rtc_regif #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_OPS = 4
) (
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_word,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  now,
    input  logic [DATA_W-1:0]  alarm,
    input  logic [DATA_W-1:0]  load_last,
    input  logic               enable,
    input  logic               irq,
    input  logic [NUM_OPS-1:0] pend,
    output logic [NUM_OPS-1:0] wr_stb,
    output logic [DATA_W-1:0]  rdata
);
    import rtc_pkg::*;

    logic wr_any;
    logic rd_any;

    assign wr_any = bus_sel && bus_wr;
    assign rd_any = bus_sel && !bus_wr;

    // Write strobe decode, one per operation kind
    always_comb begin
        wr_stb = '0;
        if (wr_any) begin
            wr_stb[OP_TIME]  = (bus_word == ADDR_W'(W_LOAD));
            wr_stb[OP_ALARM] = (bus_word == ADDR_W'(W_ALARM));
            wr_stb[OP_EN]    = (bus_word == ADDR_W'(W_ENABLE));
            wr_stb[OP_ACK]   = (bus_word == ADDR_W'(W_IRQ)) && bus_wdata[0];
        end
    end

    // Read data multiplexer
    always_comb begin
        rdata = '0;
        if (rd_any) begin
            case (bus_word)
                ADDR_W'(W_NOW):    rdata = now;
                ADDR_W'(W_ALARM):  rdata = alarm;
                ADDR_W'(W_LOAD):   rdata = load_last;
                ADDR_W'(W_ENABLE): rdata = {{(DATA_W-1){1'b0}}, enable};
                ADDR_W'(W_IRQ):    rdata = {{(DATA_W-1){1'b0}}, irq};
                ADDR_W'(W_STATUS): rdata = {{(DATA_W-NUM_OPS){1'b0}}, pend};
                default:           rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sec_rtc.sv
// Module: sec_rtc (top)
// Seconds counter with alarm, where every register write commits late
// through its own holding slot. Wires the bus decode, four slots and the
// committed-state core together.
// Assumes sec_tick is a single-cycle pulse synchronous to clk.
module sec_rtc #(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DELAY_TICKS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sec_tick,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_word,
    input  logic [rtc_pkg::DATA_W-1:0] bus_wdata,
    output logic [rtc_pkg::DATA_W-1:0] bus_rdata,
    output logic                       irq
);
    import rtc_pkg::*;

    logic [NUM_OPS-1:0] wr_stb;
    logic [NUM_OPS-1:0] status_w;
    logic [NUM_OPS-1:0] apply_w;
    logic [DATA_W-1:0]  time_held;
    logic [DATA_W-1:0]  alarm_held;
    logic               ack_held;
    logic               en_held;
    logic [DATA_W-1:0]  now_w;
    logic [DATA_W-1:0]  alarm_w;
    logic               en_w;
    logic               raw_w;
    logic               irq_w;
    logic               time_apply;
    logic               ack_apply;

    assign time_apply = apply_w[OP_TIME];
    assign ack_apply  = apply_w[OP_ACK];

    rtc_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_OPS(NUM_OPS)) u_regif (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .now       (now_w),
        .alarm     (alarm_w),
        .load_last (time_held),
        .enable    (en_w),
        .irq       (irq_w),
        .pend      (status_w),
        .wr_stb    (wr_stb),
        .rdata     (bus_rdata)
    );

    rtc_pend_slot #(.WIDTH(DATA_W), .DELAY(DELAY_TICKS)) u_slot_time (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick),
        .wr_stb(wr_stb[OP_TIME]), .wr_val(bus_wdata),
        .pending(status_w[OP_TIME]), .apply_stb(apply_w[OP_TIME]),
        .held(time_held)
    );

    rtc_pend_slot #(.WIDTH(DATA_W), .DELAY(DELAY_TICKS)) u_slot_alarm (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick),
        .wr_stb(wr_stb[OP_ALARM]), .wr_val(bus_wdata),
        .pending(status_w[OP_ALARM]), .apply_stb(apply_w[OP_ALARM]),
        .held(alarm_held)
    );

    rtc_pend_slot #(.WIDTH(1), .DELAY(DELAY_TICKS)) u_slot_ack (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick),
        .wr_stb(wr_stb[OP_ACK]), .wr_val(bus_wdata[0]),
        .pending(status_w[OP_ACK]), .apply_stb(apply_w[OP_ACK]),
        .held(ack_held)
    );

    rtc_pend_slot #(.WIDTH(1), .DELAY(DELAY_TICKS)) u_slot_en (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick),
        .wr_stb(wr_stb[OP_EN]), .wr_val(bus_wdata[0]),
        .pending(status_w[OP_EN]), .apply_stb(apply_w[OP_EN]),
        .held(en_held)
    );

    rtc_core #(.DATA_W(DATA_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (sec_tick),
        .time_apply  (apply_w[OP_TIME]),
        .time_val    (time_held),
        .alarm_apply (apply_w[OP_ALARM]),
        .alarm_val   (alarm_held),
        .ack_apply   (apply_w[OP_ACK]),
        .ack_val     (ack_held),
        .en_apply    (apply_w[OP_EN]),
        .en_val      (en_held),
        .now         (now_w),
        .alarm       (alarm_w),
        .enable      (en_w),
        .flag        (raw_w),
        .irq         (irq_w)
    );

    assign irq = irq_w;
endmodule

// File: rtl/sec_rtc_checker.sv
// Module: sec_rtc_checker
// Temporal checks on the seconds counter, bound into sec_rtc.
// Observes ports plus the count, status, flag and commit strobes.
module sec_rtc_checker #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_word,
    input logic              irq,
    input logic [31:0]       now,
    input logic [3:0]        status,
    input logic              time_apply,
    input logic              ack_apply,
    input logic              raw
);
    // R1: a tick without a time load steps the count by exactly one
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !time_apply) |=> (now == $past(now) + 32'd1));

    // R1: with no tick the count holds
    p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(now));

    // R7: a time-load write marks its status bit on the next edge
    p_load_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_word == ADDR_W'(2)) |=> status[0]);

    // R7: status bits only drop on a tick edge
    p_status_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 4'd0 && !sec_tick) |=> ((status & $past(status)) == $past(status)));

    // R4: the interrupt line can only rise on a tick edge
    p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !sec_tick) |=> !irq);

    // R5: the flag stays set until a committed acknowledge
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !ack_apply) |=> raw);
endmodule

bind sec_rtc sec_rtc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_word   (bus_word),
    .irq        (irq),
    .now        (now_w),
    .status     (status_w),
    .time_apply (time_apply),
    .ack_apply  (ack_apply),
    .raw        (raw_w)
);

// File: tb/sec_rtc_tb.sv
module sec_rtc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DLY = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference state derived from the requirements
    logic [31:0] m_now, m_alarm;
    logic        m_en, m_flag;
    logic        m_pend [4];
    int          m_cd   [4];
    logic [31:0] m_held [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_rtc #(.ADDR_W(4), .DELAY_TICKS(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_word(bus_word), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic model_reset();
        m_now = 0; m_alarm = 0; m_en = 0; m_flag = 0;
        for (int i = 0; i < 4; i++) begin
            m_pend[i] = 0; m_cd[i] = 0; m_held[i] = 0;
        end
    endtask

    // Kind index: 0 time, 1 alarm, 2 ack, 3 enable; -1 none
    function automatic int kind_of(input logic w, input logic [3:0] idx, input logic [31:0] d);
        if (!w) return -1;
        case (idx)
            4'd2: return 0;
            4'd1: return 1;
            4'd4: return d[0] ? 2 : -1;
            4'd3: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic model_step(input logic tk, input logic w, input logic [3:0] idx, input logic [31:0] d);
        logic fire [4];
        int k;
        logic hit;
        for (int i = 0; i < 4; i++) fire[i] = m_pend[i] && tk && (m_cd[i] == 1);
        hit = tk && !fire[0] && (m_now == m_alarm);
        if (fire[1]) m_alarm = m_held[1];
        if (fire[3]) m_en = m_held[3][0];
        if (hit) m_flag = 1;
        else if (fire[2]) m_flag = 0;
        if (fire[0]) m_now = m_held[0];
        else if (tk) m_now = m_now + 1;
        for (int i = 0; i < 4; i++) begin
            if (fire[i]) m_pend[i] = 0;
            else if (m_pend[i] && tk) m_cd[i] = m_cd[i] - 1;
        end
        k = kind_of(w, idx, d);
        if (k >= 0) begin
            m_held[k] = (k >= 2) ? {31'd0, d[0]} : d;
            if (!m_pend[k] || fire[k]) begin
                m_pend[k] = 1; m_cd[k] = DLY;
            end
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [3:0] idx);
        case (idx)
            4'd0: return m_now;
            4'd1: return m_alarm;
            4'd2: return m_held[0];
            4'd3: return {31'd0, m_en};
            4'd4: return {31'd0, m_flag & m_en};
            4'd5: return {28'd0, m_pend[3], m_pend[2], m_pend[1], m_pend[0]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] idx);
        case (idx)
            4'd0: return "R1";
            4'd1: return "R3";
            4'd2: return "R2";
            4'd3: return "R6";
            4'd4: return "R5";
            4'd5: return "R7";
            default: return "R10";
        endcase
    endfunction

    // One clock cycle of stimulus, model updated at the edge
    task automatic cyc(input logic tk, input logic w, input logic [3:0] idx, input logic [31:0] d);
        sec_tick = tk; bus_sel = w; bus_wr = w; bus_word = idx; bus_wdata = d;
        @(posedge clk);
        model_step(tk, w, idx, d);
        @(negedge clk);
        sec_tick = 0; bus_sel = 0; bus_wr = 0;
    endtask

    task automatic chk_reg(input logic [3:0] idx, input string req);
        logic [31:0] e;
        bus_sel = 1; bus_wr = 0; bus_word = idx;
        #1;
        e = exp_read(idx);
        total++;
        if (bus_rdata !== e) begin
            bad++;
            $display("FAIL %s word %0d actual=%h expected=%h", req, idx, bus_rdata, e);
        end
        bus_sel = 0;
    endtask

    task automatic chk_irq(input string req);
        total++;
        if (irq !== (m_flag & m_en)) begin
            bad++;
            $display("FAIL %s irq actual=%b expected=%b", req, irq, m_flag & m_en);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        @(negedge clk);
        do_reset();

        // R9: everything zero after reset
        for (int i = 0; i < 8; i++) chk_reg(4'(i), "R9");
        chk_irq("R9");

        // R1: write to word 0 ignored, tick increments
        cyc(0, 1, 4'd0, 32'hDEAD_BEEF);
        cyc(1, 0, 4'd0, 0);
        chk_reg(4'd0, "R1");

        // R2 / R7: time load lands on the second tick, last-written readback
        cyc(0, 1, 4'd2, 32'd100);
        chk_reg(4'd5, "R7");
        chk_reg(4'd2, "R2");
        cyc(1, 0, 4'd0, 0);
        chk_reg(4'd0, "R2");
        cyc(1, 0, 4'd0, 0);
        chk_reg(4'd0, "R2");
        chk_reg(4'd5, "R7");

        // R8: rewrite replaces value, countdown kept
        cyc(0, 1, 4'd1, 32'd5);
        cyc(1, 0, 4'd0, 0);
        cyc(0, 1, 4'd1, 32'd7);
        chk_reg(4'd1, "R8");
        cyc(1, 0, 4'd0, 0);
        chk_reg(4'd1, "R8");
        chk_reg(4'd5, "R8");

        // R6: enable commit
        cyc(0, 1, 4'd3, 32'd1);
        cyc(1, 0, 4'd0, 0);
        chk_reg(4'd3, "R6");
        cyc(1, 0, 4'd0, 0);
        chk_reg(4'd3, "R6");

        // R4: load 6, count reaches alarm 7, flag on the tick leaving 7
        cyc(0, 1, 4'd2, 32'd6);
        cyc(1, 0, 4'd0, 0);
        cyc(1, 0, 4'd0, 0);
        cyc(1, 0, 4'd0, 0);
        chk_irq("R4");
        cyc(1, 0, 4'd0, 0);
        chk_irq("R4");
        chk_reg(4'd4, "R4");

        // R5: ack with bit0=0 ignored, ack with bit0=1 clears late
        cyc(0, 1, 4'd4, 32'd0);
        chk_reg(4'd5, "R5");
        chk_irq("R5");
        cyc(0, 1, 4'd4, 32'd1);
        cyc(1, 0, 4'd0, 0);
        chk_irq("R5");
        cyc(1, 0, 4'd0, 0);
        chk_irq("R5");
        chk_reg(4'd4, "R5");

        // R10: unmapped write and read
        cyc(0, 1, 4'd9, 32'hFFFF_FFFF);
        chk_reg(4'd9, "R10");
        chk_reg(4'd5, "R10");

        // R1: wrap at the top of the range
        cyc(0, 1, 4'd2, 32'hFFFF_FFFF);
        cyc(1, 0, 4'd0, 0);
        cyc(1, 0, 4'd0, 0);
        cyc(1, 0, 4'd0, 0);
        chk_reg(4'd0, "R1");

        // Random traffic with values biased toward the alarm
        for (int n = 0; n < 4000; n++) begin
            logic        tk, w;
            logic [3:0]  idx;
            logic [31:0] d;
            tk = ($urandom % 3) == 0;
            w = ($urandom % 4) == 0;
            idx = 4'($urandom % 8);
            case (idx)
                4'd1: d = m_now + ($urandom % 4);
                4'd2: d = ($urandom % 2) ? m_alarm - ($urandom % 3) : $urandom;
                4'd3, 4'd4: d = $urandom % 2;
                default: d = $urandom;
            endcase
            cyc(tk, w, idx, d);
            chk_irq("R4");
            begin
                logic [3:0] r;
                r = 4'($urandom % 8);
                chk_reg(r, req_of(r));
            end
        end

        // R9: reset in the middle of activity
        cyc(0, 1, 4'd2, 32'd55);
        do_reset();
        for (int i = 0; i < 6; i++) chk_reg(4'(i), "R9");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule